// File: doc/BRIEF.md
# Low-Power Clock State Controller

This block moves a system-on-chip between three power states: Operating, Idle and Standby. Software requests a state change with one-cycle write strobes. Raw interrupt lines wake the system. Every interrupt line passes through a two-flop synchronizer. Lines chosen by a parameter mask also pass through a deglitcher, which samples them on rising edges of a slow real-time clock.

Idle stops only the CPU clock. The oscillator and the PLL keep running, so the exit is quick. Standby also stops the main oscillator, stops the PLL when PLL mode is selected, and drops the RUN output. In crystal mode with the configuration bit low, Standby also pulls the external clock-enable pin low so that an external oscillator can be switched off. On leaving Standby, the oscillator is restarted first. A programmable settling count then runs out before the CPU clock comes back.

The controller runs on an always-on reference clock. The clock enables it drives go to the gating and oscillator cells.

Top module: `lp_clk_state_ctrl`

## Requirements
- R1: After reset, `state_o` is 2'b00 (Operating) and `cpu_clk_en_o`, `osc_en_o`, `clken_o` and `run_o` are high. `pll_en_o` equals `pll_mode_i`. The codes are 2'b00 Operating, 2'b01 Idle and 2'b10 Standby; 2'b11 never appears.
- R2: A line that is not deglitched appears on `irq_acc_o` two rising clock edges after it is driven on `irq_i`.
- R3: A deglitched line is accepted only after it has been seen high at two successive rising edges of `rtc_clk_i` (after that clock is synchronized). If the line is seen low, its count restarts. A shorter pulse never reaches `irq_acc_o` and never wakes the block.
- R4: A `wr_idle_i` pulse in Operating enters Idle (2'b01). Idle lowers `cpu_clk_en_o` and keeps `osc_en_o`, `clken_o` and `run_o` high.
- R5: In Idle, an accepted line whose `irq_en_i` bit is 1 raises `cpu_clk_en_o` two edges after acceptance, which is the fourth edge after a non-deglitched raw edge. A line whose `irq_en_i` bit is 0 does not wake.
- R6: Standby (2'b10) lowers `osc_en_o`, `pll_en_o`, `run_o` and `cpu_clk_en_o`.
- R7: In Standby, `clken_o` is low only when `pll_mode_i` is 0 and `clkensl_i` is 0. Otherwise `clken_o` is high.
- R8: A `wr_stdby_i` pulse is ignored while any accepted line with its `irq_en_i` bit set is pending. A pending line whose enable bit is 0 does not block the request.
- R9: On leaving Standby, `osc_en_o` (and `pll_en_o` in PLL mode) rise one edge after the pending interrupt is seen. `cpu_clk_en_o` and `run_o` rise `settle_cnt_i`+1 edges after that.
- R10: Request strobes are ignored outside Operating. If both strobes arrive together in Operating, Standby wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Active-low reset |
| rtc_clk_i | input | 1 | Slow real-time clock used by the deglitcher |
| irq_i | input | N_IRQ | Raw interrupt request lines |
| irq_en_i | input | N_IRQ | Per-line enable for wake and standby blocking |
| wr_idle_i | input | 1 | One-cycle request to enter Idle |
| wr_stdby_i | input | 1 | One-cycle request to enter Standby |
| pll_mode_i | input | 1 | 1 selects PLL clock mode, 0 selects crystal mode |
| clkensl_i | input | 1 | 1 keeps the external clock enable high in Standby (crystal mode) |
| settle_cnt_i | input | SETTLE_W | Oscillator settling count applied on Standby exit |
| irq_acc_o | output | N_IRQ | Synchronized (and deglitched) interrupt lines |
| state_o | output | 2 | Power state code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clken_o | output | 1 | External clock-enable pin |
| run_o | output | 1 | System run indicator |

## Verification
Wake latency is measured edge by edge for three paths, which tells apart an off-by-one in the synchronizer, in the Idle restart and in the settling counter. The three paths are a plain line to the accepted output, Idle to Operating, and Standby to Operating with a settling count of 5. Standby is entered under all three combinations of clock mode and configuration bit. This shows whether the external clock-enable pin follows the mode and the bit or merely follows the state. The deglitched line gets two patterns, a pulse spanning one slow edge and a level held across two, which shows whether the count really needs both samples. Enabled and masked pending lines are set against a Standby request, and strobes are sent inside Standby and together in Operating, to check the blocking and priority rules.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;

    typedef enum logic [2:0] {
        PS_OPER      = 3'd0,
        PS_IDLE      = 3'd1,
        PS_STBY      = 3'd2,
        PS_IDLE_EXIT = 3'd3,
        PS_SETTLE    = 3'd4
    } pstate_e;

    localparam logic [1:0] CODE_OPER = 2'b00;
    localparam logic [1:0] CODE_IDLE = 2'b01;
    localparam logic [1:0] CODE_STBY = 2'b10;

    function automatic logic [1:0] state_code(input pstate_e s);
        case (s)
            PS_IDLE, PS_IDLE_EXIT: state_code = CODE_IDLE;
            PS_STBY, PS_SETTLE:    state_code = CODE_STBY;
            default:               state_code = CODE_OPER;
        endcase
    endfunction

endpackage

// File: rtl/lpcs_sync.sv
module lpcs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.pipe[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            r_d.pipe[s] = r_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign q_o = r_q.pipe[STAGES-1];
endmodule

// File: rtl/lpcs_rtc_edge.sv
module lpcs_rtc_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rtc_clk_i,
    output logic rise_o
);
    logic rtc_s;
    logic last_d, last_q;

    lpcs_sync #(.WIDTH(1), .STAGES(2)) u_rtc_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rtc_clk_i),
        .q_o    (rtc_s)
    );

    always_comb begin
        last_d = rtc_s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= last_d;
    end

    assign rise_o = rtc_s & ~last_q;
endmodule

// File: rtl/lpcs_deglitch.sv
module lpcs_deglitch #(
    parameter int             N_IRQ   = 4,
    parameter logic [N_IRQ-1:0] DG_MASK = '0,
    parameter int             DG_LEN  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [N_IRQ-1:0] sync_i,
    output logic [N_IRQ-1:0] acc_o
);
    localparam int CW = $clog2(DG_LEN + 1);
    localparam logic [CW-1:0] CMAX = CW'(DG_LEN);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        if (DG_MASK[i]) begin : g_filt
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!sync_i[i]) begin
                    cnt_d = '0;
                end else if (tick_i && cnt_q != CMAX) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign acc_o[i] = sync_i[i] && (cnt_q == CMAX);
        end else begin : g_pass
            assign acc_o[i] = sync_i[i];
        end
    end

    logic unused_tick;
    assign unused_tick = (DG_MASK == '0) & tick_i;
endmodule

// File: rtl/lpcs_fsm.sv
module lpcs_fsm
    import lpcs_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                pend_i,
    input  logic                wr_idle_i,
    input  logic                wr_stdby_i,
    input  logic                pll_mode_i,
    input  logic                clkensl_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    output logic [1:0]          state_o,
    output logic                cpu_clk_en_o,
    output logic                osc_en_o,
    output logic                pll_en_o,
    output logic                clken_o,
    output logic                run_o
);
    typedef struct packed {
        pstate_e             st;
        logic [SETTLE_W-1:0] cnt;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.st)
            PS_OPER: begin
                if (wr_stdby_i && !pend_i) begin
                    f_d.st = PS_STBY;
                end else if (wr_idle_i) begin
                    f_d.st = PS_IDLE;
                end
            end
            PS_IDLE: begin
                if (pend_i) f_d.st = PS_IDLE_EXIT;
            end
            PS_IDLE_EXIT: begin
                f_d.st = PS_OPER;
            end
            PS_STBY: begin
                if (pend_i) begin
                    f_d.st  = PS_SETTLE;
                    f_d.cnt = settle_cnt_i;
                end
            end
            PS_SETTLE: begin
                if (f_q.cnt == '0) begin
                    f_d.st = PS_OPER;
                end else begin
                    f_d.cnt = f_q.cnt - 1'b1;
                end
            end
            default: f_d.st = PS_OPER;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q.st  <= PS_OPER;
            f_q.cnt <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    logic stopped;
    assign stopped      = (f_q.st == PS_STBY);
    assign state_o      = state_code(f_q.st);
    assign cpu_clk_en_o = (f_q.st == PS_OPER);
    assign osc_en_o     = !stopped;
    assign pll_en_o     = pll_mode_i && !stopped;
    assign clken_o      = !(stopped && !pll_mode_i && !clkensl_i);
    assign run_o        = (f_q.st == PS_OPER) || (f_q.st == PS_IDLE) ||
                          (f_q.st == PS_IDLE_EXIT);
endmodule

// File: rtl/lp_clk_state_ctrl.sv
module lp_clk_state_ctrl #(
    parameter int               N_IRQ    = 4,
    parameter logic [N_IRQ-1:0] DG_MASK  = 4'b1000,
    parameter int               DG_LEN   = 2,
    parameter int               SYNC_LEN = 2,
    parameter int               SETTLE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                rtc_clk_i,
    input  logic [N_IRQ-1:0]    irq_i,
    input  logic [N_IRQ-1:0]    irq_en_i,
    input  logic                wr_idle_i,
    input  logic                wr_stdby_i,
    input  logic                pll_mode_i,
    input  logic                clkensl_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    output logic [N_IRQ-1:0]    irq_acc_o,
    output logic [1:0]          state_o,
    output logic                cpu_clk_en_o,
    output logic                osc_en_o,
    output logic                pll_en_o,
    output logic                clken_o,
    output logic                run_o
);
    logic [N_IRQ-1:0] irq_s;
    logic             rtc_rise;
    logic             pend;

    lpcs_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_LEN)) u_irq_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (irq_i),
        .q_o    (irq_s)
    );

    lpcs_rtc_edge u_rtc_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rtc_clk_i (rtc_clk_i),
        .rise_o    (rtc_rise)
    );

    lpcs_deglitch #(.N_IRQ(N_IRQ), .DG_MASK(DG_MASK), .DG_LEN(DG_LEN)) u_dg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (rtc_rise),
        .sync_i (irq_s),
        .acc_o  (irq_acc_o)
    );

    assign pend = |(irq_acc_o & irq_en_i);

    lpcs_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pend_i       (pend),
        .wr_idle_i    (wr_idle_i),
        .wr_stdby_i   (wr_stdby_i),
        .pll_mode_i   (pll_mode_i),
        .clkensl_i    (clkensl_i),
        .settle_cnt_i (settle_cnt_i),
        .state_o      (state_o),
        .cpu_clk_en_o (cpu_clk_en_o),
        .osc_en_o     (osc_en_o),
        .pll_en_o     (pll_en_o),
        .clken_o      (clken_o),
        .run_o        (run_o)
    );
endmodule

// File: rtl/lp_clk_state_ctrl_chk.sv
module lp_clk_state_ctrl_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_IRQ-1:0] irq_acc_o,
    input logic [N_IRQ-1:0] irq_en_i,
    input logic             wr_stdby_i,
    input logic [1:0]       state_o,
    input logic             cpu_clk_en_o,
    input logic             osc_en_o,
    input logic             pll_en_o,
    input logic             clken_o,
    input logic             run_o
);
    AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 2'b11); // R1

    AST_IDLE_KEEPS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b01) |-> (osc_en_o && run_o && clken_o && !cpu_clk_en_o)); // R4

    AST_OSC_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !osc_en_o |-> (!pll_en_o && !run_o && !cpu_clk_en_o && state_o == 2'b10)); // R6

    AST_CLKEN_WITH_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_en_o |-> clken_o); // R7

    AST_STBY_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b00 && wr_stdby_i && |(irq_acc_o & irq_en_i)) |=> (state_o != 2'b10)); // R8

    AST_CPU_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_clk_en_o |-> (run_o && osc_en_o)); // R9

    AST_OSC_BEFORE_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(osc_en_o)) |-> !cpu_clk_en_o); // R9
endmodule

bind lp_clk_state_ctrl lp_clk_state_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_acc_o    (irq_acc_o),
    .irq_en_i     (irq_en_i),
    .wr_stdby_i   (wr_stdby_i),
    .state_o      (state_o),
    .cpu_clk_en_o (cpu_clk_en_o),
    .osc_en_o     (osc_en_o),
    .pll_en_o     (pll_en_o),
    .clken_o      (clken_o),
    .run_o        (run_o)
);

// File: tb/tb_lp_clk_state_ctrl.sv
`timescale 1ns/1ps
module tb_lp_clk_state_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_clk = 1'b0;
    logic [3:0] irq = '0;
    logic [3:0] irq_en = 4'b1111;
    logic       wr_idle = 1'b0;
    logic       wr_stdby = 1'b0;
    logic       pll_mode = 1'b0;
    logic       clkensl = 1'b0;
    logic [7:0] settle = 8'd5;
    logic [3:0] acc;
    logic [1:0] state;
    logic       cpu_en, osc_en, pll_en, clken, run;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag_q[$];
    int    val_q[$];

    always #4 clk = ~clk;

    lp_clk_state_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .rtc_clk_i(rtc_clk), .irq_i(irq),
        .irq_en_i(irq_en), .wr_idle_i(wr_idle), .wr_stdby_i(wr_stdby),
        .pll_mode_i(pll_mode), .clkensl_i(clkensl), .settle_cnt_i(settle),
        .irq_acc_o(acc), .state_o(state), .cpu_clk_en_o(cpu_en),
        .osc_en_o(osc_en), .pll_en_o(pll_en), .clken_o(clken), .run_o(run)
    );

    initial begin
        forever begin
            repeat (20) @(negedge clk);
            rtc_clk = ~rtc_clk;
        end
    end

    // driver side: expected value goes into the scoreboard
    task automatic push_exp(input string tag, input int val);
        tag_q.push_back(tag);
        val_q.push_back(val);
    endtask

    // monitor side: observed value is compared with the oldest expectation
    task automatic mon_cmp(input int act);
        string t;
        int e;
        t = tag_q.pop_front();
        e = val_q.pop_front();
        total++;
        if (act != e) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, e);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        push_exp(tag, exp);
        mon_cmp(act);
    endtask

    task automatic pulse(input bit idle, input bit stby);
        wr_idle = idle;
        wr_stdby = stby;
        @(negedge clk);
        wr_idle = 1'b0;
        wr_stdby = 1'b0;
        @(negedge clk);
    endtask

    // counts edges from a stimulus change until osc and cpu enables rise
    task automatic wake_meas(output int n_osc, output int n_cpu, output int run_at_osc);
        n_osc = 0; n_cpu = 0; run_at_osc = -1;
        for (int k = 1; k <= 300; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (osc_en && n_osc == 0) begin
                n_osc = k;
                run_at_osc = int'(run);
            end
            if (cpu_en) begin
                n_cpu = k;
                break;
            end
        end
    endtask

    task automatic wait_rtc_rise(input int extra);
        @(posedge rtc_clk);
        repeat (extra) @(negedge clk);
    endtask

    initial begin
        int n_osc, n_cpu, r_osc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset values
        chk("R1 state", state, 0);
        chk("R1 cpu_clk_en", cpu_en, 1);
        chk("R1 osc/clken/run", {osc_en, clken, run}, 7);
        chk("R1 pll_en follows mode", pll_en, 0);

        // synchronizer delay on a plain line
        irq[0] = 1'b1;
        n_cpu = 0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (acc[0]) begin n_cpu = k; break; end
        end
        chk("R2 sync edges", n_cpu, 2);
        irq[0] = 1'b0;
        repeat (4) @(negedge clk);

        // idle entry
        pulse(1, 0);
        chk("R4 idle code", state, 1);
        chk("R4 idle cpu off, osc/clken/run kept", {cpu_en, osc_en, clken, run}, 7);

        // masked line does not wake idle
        irq_en = 4'b1110;
        irq[0] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 masked no wake", state, 1);
        irq[0] = 1'b0;
        repeat (4) @(negedge clk);
        irq_en = 4'b1111;
        @(negedge clk);
        irq[0] = 1'b1;
        wake_meas(n_osc, n_cpu, r_osc);
        chk("R5 idle restart edges", n_cpu, 4);
        chk("R5 back to operating", state, 0);
        irq[0] = 1'b0;
        repeat (4) @(negedge clk);

        // both strobes: standby wins; crystal mode, config bit low
        pulse(1, 1);
        chk("R10 standby wins", state, 2);
        chk("R6 osc/pll/run/cpu off", {osc_en, pll_en, run, cpu_en}, 0);
        chk("R7 clken low crystal cfg0", clken, 0);
        pulse(1, 0);
        chk("R10 idle strobe ignored in standby", state, 2);
        irq[1] = 1'b1;
        wake_meas(n_osc, n_cpu, r_osc);
        chk("R9 osc restart edge", n_osc, 3);
        chk("R9 run low while settling", r_osc, 0);
        chk("R9 cpu after settle", n_cpu, 9);
        chk("R9 run with cpu", run, 1);
        irq[1] = 1'b0;
        repeat (4) @(negedge clk);

        // crystal mode, config bit high
        clkensl = 1'b1;
        pulse(0, 1);
        chk("R7 clken high crystal cfg1", {state, clken}, 5);
        irq[1] = 1'b1;
        wake_meas(n_osc, n_cpu, r_osc);
        irq[1] = 1'b0;
        repeat (4) @(negedge clk);

        // PLL mode
        clkensl = 1'b0;
        pll_mode = 1'b1;
        @(negedge clk);
        chk("R1 pll_en in PLL mode", pll_en, 1);
        pulse(0, 1);
        chk("R6 pll off in standby", pll_en, 0);
        chk("R7 clken high PLL mode", clken, 1);
        settle = 8'd2;
        irq[0] = 1'b1;
        wake_meas(n_osc, n_cpu, r_osc);
        chk("R9 settle 2 cpu edges", n_cpu, 6);
        chk("R9 pll back", pll_en, 1);
        irq[0] = 1'b0;
        pll_mode = 1'b0;
        settle = 8'd5;
        repeat (4) @(negedge clk);

        // standby blocked by enabled pending line
        irq[2] = 1'b1;
        repeat (4) @(negedge clk);
        pulse(0, 1);
        chk("R8 standby refused", {state, cpu_en}, 1);
        irq_en = 4'b1011;
        @(negedge clk);
        pulse(0, 1);
        chk("R8 masked pending does not block", state, 2);
        irq[0] = 1'b1;
        wake_meas(n_osc, n_cpu, r_osc);
        irq[0] = 1'b0;
        irq[2] = 1'b0;
        irq_en = 4'b1111;
        repeat (4) @(negedge clk);

        // deglitched line: short pulse rejected
        pulse(1, 0);
        wait_rtc_rise(1);
        irq[3] = 1'b1;
        wait_rtc_rise(10);
        chk("R3 one slow edge no wake", state, 1);
        irq[3] = 1'b0;
        wait_rtc_rise(10);
        chk("R3 short pulse never accepted", {state, 1'b0, acc[3]}, 4);
        irq[0] = 1'b1;
        wake_meas(n_osc, n_cpu, r_osc);
        irq[0] = 1'b0;
        repeat (4) @(negedge clk);

        // deglitched line: held across two slow edges
        pulse(1, 0);
        wait_rtc_rise(1);
        irq[3] = 1'b1;
        wait_rtc_rise(10);
        chk("R3 held, after first slow edge", state, 1);
        wait_rtc_rise(10);
        chk("R3 held, accepted after second", {state, cpu_en, acc[3]}, 3);
        irq[3] = 1'b0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule